// File: doc/BRIEF.md
# Wakeup Interrupt Aggregator

This block watches thirty-two external wakeup inputs. Every input passes through a two-flop synchronizer and then a per-pin trigger detector. The detector can be set to rising edge, falling edge, both edges, level high or level low. A detected trigger latches a pending bit. Software clears a pending bit by writing a one to it, and a mask bit holds the pending bit back from the interrupt outputs.

The sources are grouped into four banks of eight. Source n sits in bank n/8 at pin position n mod 8. Each bank has a control word, a mask word and a pending word, and these are reached over a simple register bus.

Sources 0 to 15 each drive their own interrupt line. Sources 16 to 31 are merged onto one shared line. A handler for the shared line reads the two upper pending words, or a cause register that reports the highest-numbered source that is pending and unmasked. The handler services that source and repeats until the cause register shows no source.

Top module: `wkup_irq_agg`

## Requirements
- R1: Source n maps to bank n/8, bit n mod 8. The control, mask and pending words of bank b are at byte address 0x00+4b, 0x10+4b and 0x20+4b. A mask or pending read returns the eight bits in [7:0] and zeros above them.
- R2: Pin p of a bank is configured by control bits [4p+3:4p]. The codes are: 0 level low, 1 level high, 2 falling edge, 3 rising edge, and any value of 4 or above both edges. An edge of the opposite direction to the one selected sets nothing.
- R3: An edge trigger sets the pending bit once per qualifying edge, and the bit stays set after the input returns. A level trigger sets the pending bit again on every cycle the level is present, so a clear does not stick while the level lasts.
- R4: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Software cannot set a pending bit.
- R5: irq_direct[n], for n from 0 to 15, is high exactly when source n is pending and its mask bit is 0. A mask bit of 1 blocks the output, but the pending bit still shows in the pending word.
- R6: irq_shared is the OR of pending, unmasked sources 16 to 31. Those sources never drive irq_direct.
- R7: The pending bits of sources 16–23 are read at 0x28, and those of sources 24–31 at 0x2C.
- R8: The cause register at 0x30 holds the number of the highest pending, unmasked source in 16..31 in bits [4:0], with a valid flag in bit 8. It reads 0 when no such source exists.
- R9: A rising input that is unmasked and set to rising edge drives its irq_direct line high on the fourth rising clock edge after the input changes, and not before.
- R10: After reset, every mask bit is 1, no bit is pending, every control field holds code 3, all interrupt outputs are low and read data is 0.
- R11: A read returns its data on reg_rdata at the clock edge that samples reg_rd. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| wkup_in | input | 32 | Asynchronous wakeup inputs |
| irq_direct | output | 16 | One interrupt line for each of sources 0–15 |
| irq_shared | output | 1 | Combined interrupt line for sources 16–31 |

## Verification
The hardest situation to reach from the ports is the shared-line handling sequence, where several upper sources are pending at once and the cause register has to step down from the highest to the next one as each is cleared. The stimulus first raises two upper sources while both are masked, so they latch pending bits without firing anything. It then unmasks them one at a time and clears the top one. The cause value is checked at every step. The level-trigger re-set is reached by clearing a pending bit while the input is still held at its active level.

// File: rtl/wke_pkg.sv
package wke_pkg;
  localparam logic [3:0] TRG_LVL_LO = 4'd0;
  localparam logic [3:0] TRG_LVL_HI = 4'd1;
  localparam logic [3:0] TRG_FALL   = 4'd2;
  localparam logic [3:0] TRG_RISE   = 4'd3;

  // any code of 4 or more selects both edges
  function automatic logic trig_hit(input logic [3:0] code, input logic cur, input logic prv);
    case (code)
      TRG_LVL_LO: trig_hit = !cur;
      TRG_LVL_HI: trig_hit = cur;
      TRG_FALL:   trig_hit = !cur && prv;
      TRG_RISE:   trig_hit = cur && !prv;
      default:    trig_hit = cur ^ prv;
    endcase
  endfunction
endpackage

// File: rtl/wke_sync.sv
module wke_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);
  logic [N-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      cur  <= '0;
      prv  <= '0;
    end else begin
      meta <= raw;
      cur  <= meta;
      prv  <= cur;
    end
  end
endmodule

// File: rtl/wke_detect.sv
module wke_detect #(
  parameter int N  = 32,
  parameter int FW = 4
) (
  input  logic [N*FW-1:0] cfg,
  input  logic [N-1:0]    cur,
  input  logic [N-1:0]    prv,
  output logic [N-1:0]    hit
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = wke_pkg::trig_hit(cfg[i*FW +: 4], cur[i], prv[i]);
  end
endmodule

// File: rtl/wke_prio.sv
module wke_prio #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [IW-1:0] idx
);
  // scan upward; the last set bit found is the highest
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wkup_irq_agg.sv
module wkup_irq_agg #(
  parameter int          BANKS     = 4,
  parameter int          PINS      = 8,
  parameter int          FIELD_W   = 4,
  parameter int          DIRECT    = 16,
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [3:0]  CTRL_RGN  = 4'h0,
  parameter logic [3:0]  MASK_RGN  = 4'h1,
  parameter logic [3:0]  PEND_RGN  = 4'h2,
  parameter logic [3:0]  CAUSE_RGN = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [31:0]       wkup_in,
  output logic [DIRECT-1:0] irq_direct,
  output logic              irq_shared
);
  localparam int NSRC   = BANKS * PINS;
  localparam int SHARED = NSRC - DIRECT;
  localparam int BAW    = $clog2(BANKS);
  localparam int IW     = $clog2(SHARED);

  logic [DATA_W-1:0] ctrl_q [BANKS];
  logic [NSRC-1:0]   mask_q, pend_q, clr, evt, act;
  logic [NSRC-1:0]   s_cur, s_prv;
  logic [NSRC*FIELD_W-1:0] cfg_flat;
  logic [ADDR_W-5:0] rgn;
  logic [BAW-1:0]    bsel;
  logic              c_valid;
  logic [IW-1:0]     c_idx;
  logic [DATA_W-1:0] cause_word;
  logic              unused_bits;

  assign rgn  = reg_addr[ADDR_W-1:4];
  assign bsel = reg_addr[2 +: BAW];
  assign unused_bits = ^{reg_wdata[DATA_W-1:PINS], reg_addr[1:0]};

  wke_sync #(.N(NSRC)) u_sync (
    .clk(clk), .rst(rst), .raw(wkup_in[NSRC-1:0]), .cur(s_cur), .prv(s_prv)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_cfg
    assign cfg_flat[b*DATA_W +: DATA_W] = ctrl_q[b];
  end

  wke_detect #(.N(NSRC), .FW(FIELD_W)) u_det (
    .cfg(cfg_flat), .cur(s_cur), .prv(s_prv), .hit(evt)
  );

  always_comb begin
    clr = '0;
    if (reg_wr && rgn == (ADDR_W-4)'(PEND_RGN))
      clr[bsel*PINS +: PINS] = reg_wdata[PINS-1:0];
  end

  assign act = pend_q & ~mask_q;

  wke_prio #(.N(SHARED), .IW(IW)) u_prio (
    .req(act[NSRC-1:DIRECT]), .valid(c_valid), .idx(c_idx)
  );

  always_comb begin
    cause_word = '0;
    if (c_valid) begin
      cause_word[8]   = 1'b1;
      cause_word[7:0] = 8'(c_idx) + 8'(DIRECT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++)
        ctrl_q[b] <= {PINS{wke_pkg::TRG_RISE}};
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (reg_wr && rgn == (ADDR_W-4)'(CTRL_RGN))
        ctrl_q[bsel] <= reg_wdata;
      if (reg_wr && rgn == (ADDR_W-4)'(MASK_RGN))
        mask_q[bsel*PINS +: PINS] <= reg_wdata[PINS-1:0];
      pend_q <= (pend_q & ~clr) | evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      irq_direct <= '0;
      irq_shared <= 1'b0;
    end else begin
      irq_direct <= act[DIRECT-1:0];
      irq_shared <= |act[NSRC-1:DIRECT];
      if (reg_rd) begin
        reg_rdata <= '0;
        case (rgn)
          (ADDR_W-4)'(CTRL_RGN):  reg_rdata <= ctrl_q[bsel];
          (ADDR_W-4)'(MASK_RGN):  reg_rdata[PINS-1:0] <= mask_q[bsel*PINS +: PINS];
          (ADDR_W-4)'(PEND_RGN):  reg_rdata[PINS-1:0] <= pend_q[bsel*PINS +: PINS];
          (ADDR_W-4)'(CAUSE_RGN): reg_rdata <= cause_word;
          default:                reg_rdata <= '0;
        endcase
      end
    end
  end

  // R10: state right after reset
  p_reset_state_r10: assert property (@(posedge clk)
    $fell(rst) |-> (mask_q == '1 && pend_q == '0 && irq_direct == '0 && !irq_shared));

  // R4: a pending bit only rises after a detected trigger
  p_pend_from_event_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~$past(pend_q) & ~$past(evt)) == '0);

  // R5: a direct line never fires for a source masked the cycle before
  p_direct_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_direct & $past(mask_q[DIRECT-1:0])) == '0);

  // R8: the reported source is requesting and nothing above it is
  p_cause_highest_r8: assert property (@(posedge clk) disable iff (rst)
    c_valid |-> ((act[NSRC-1:DIRECT] >> c_idx) == SHARED'(1)));

  // R6: the shared line stays low while every upper source is masked
  p_shared_masked_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q[NSRC-1:DIRECT]) == '1) |-> !irq_shared);
endmodule

// File: tb/sim_wkup_irq_agg.sv
`timescale 1ns/1ps
module sim_wkup_irq_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] wkup_in = '0;
  logic [15:0] irq_direct;
  logic        irq_shared;

  int nchk = 0, nfail = 0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wkup_irq_agg u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wkup_in(wkup_in),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data pushed by the driver
  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("R11 unexpected read", reg_rdata, 32'hx);
      else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pin(input int n, input logic v);
    @(negedge clk);
    wkup_in[n] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R10 reset state
    chk("R10 irq_direct", {16'h0, irq_direct}, 32'h0);
    chk("R10 irq_shared", {31'h0, irq_shared}, 32'h0);
    chk("R10 rdata", reg_rdata, 32'h0);
    for (int b = 0; b < 4; b++) begin
      rd(8'h10 + 8'(4*b), 32'h000000FF, "R10 mask");
      rd(8'h20 + 8'(4*b), 32'h0, "R10 pend");
    end
    rd(8'h00, 32'h33333333, "R10 ctrl");
    rd(8'h44, 32'h0, "R11 unmapped");

    // R1 R3 R5: source 3 rising edge
    wr(8'h10, 32'hF7);
    pin(3, 1'b1); tick(6);
    chk("R5 direct src3", {16'h0, irq_direct}, 32'h0008);
    rd(8'h20, 32'h08, "R1 pend bank0");
    pin(3, 1'b0); tick(6);
    rd(8'h20, 32'h08, "R3 edge stays");
    wr(8'h20, 32'h00); tick(3);
    rd(8'h20, 32'h08, "R4 write zero");
    wr(8'h20, 32'h08); tick(3);
    rd(8'h20, 32'h00, "R4 w1c");
    chk("R4 irq after clear", {16'h0, irq_direct}, 32'h0);

    // R5 masked source 5
    pin(5, 1'b1); tick(6);
    rd(8'h20, 32'h20, "R5 masked pend");
    chk("R5 masked no irq", {16'h0, irq_direct}, 32'h0);
    wr(8'h10, 32'hD7); tick(3);
    chk("R5 unmask irq", {16'h0, irq_direct}, 32'h0020);
    wr(8'h20, 32'h20); pin(5, 1'b0); tick(3);

    // R2 falling on source 9
    wr(8'h04, 32'h33333323); wr(8'h14, 32'hFD);
    pin(9, 1'b1); tick(6);
    rd(8'h24, 32'h0, "R2 falling ignores rise");
    chk("R2 no irq", {16'h0, irq_direct}, 32'h0);
    pin(9, 1'b0); tick(6);
    rd(8'h24, 32'h02, "R2 falling pend");
    chk("R2 irq src9", {16'h0, irq_direct}, 32'h0200);
    wr(8'h24, 32'h02);

    // R2 both edges on source 10
    wr(8'h04, 32'h33333423); wr(8'h14, 32'hF9);
    pin(10, 1'b1); tick(6);
    rd(8'h24, 32'h04, "R2 both rise");
    wr(8'h24, 32'h04);
    pin(10, 1'b0); tick(6);
    rd(8'h24, 32'h04, "R2 both fall");
    wr(8'h24, 32'h04);

    // R3 level high on source 12
    wr(8'h04, 32'h33313423);
    pin(12, 1'b1); tick(6);
    wr(8'h24, 32'h10); tick(3);
    rd(8'h24, 32'h10, "R3 level resets pend");
    pin(12, 1'b0); tick(6);
    wr(8'h24, 32'h10); tick(3);
    rd(8'h24, 32'h0, "R3 level gone");

    // R2 level low on source 13 (input already low)
    wr(8'h04, 32'h33013423); tick(6);
    rd(8'h24, 32'h20, "R2 level low");
    wr(8'h04, 32'h33313423); wr(8'h24, 32'h20); tick(3);
    rd(8'h24, 32'h0, "R2 level low cleared");

    // R6 R7 R8 shared line
    pin(17, 1'b1); pin(29, 1'b1); tick(6);
    chk("R6 masked shared", {31'h0, irq_shared}, 32'h0);
    rd(8'h28, 32'h02, "R7 pend 16-23");
    rd(8'h2C, 32'h20, "R7 pend 24-31");
    rd(8'h30, 32'h0, "R8 none");
    wr(8'h18, 32'hFD); tick(3);
    chk("R6 shared up", {31'h0, irq_shared}, 32'h1);
    rd(8'h30, 32'h111, "R8 src17");
    wr(8'h1C, 32'hDF); tick(3);
    rd(8'h30, 32'h11D, "R8 src29 highest");
    chk("R6 direct untouched", {16'h0, irq_direct}, 32'h0);
    wr(8'h2C, 32'h20); tick(3);
    rd(8'h30, 32'h111, "R8 step down");
    wr(8'h28, 32'h02); tick(3);
    rd(8'h30, 32'h0, "R8 empty");
    chk("R6 shared down", {31'h0, irq_shared}, 32'h0);

    // R9 latency on source 0
    wr(8'h10, 32'hD6);
    @(negedge clk); wkup_in[0] = 1'b1;
    tick(3);
    chk("R9 not before edge 4", {31'h0, irq_direct[0]}, 32'h0);
    tick(1);
    chk("R9 at edge 4", {31'h0, irq_direct[0]}, 32'h1);

    tick(4);
    chk("R11 queue drained", 32'(exp_q.size()), 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule